// File: doc/BRIEF.md
# Synthesizer Divider Settings Register with Source Select

This block holds the four divider settings a frequency synthesizer runs from: a 10-bit feedback count, a 3-bit output post-divider code, a 1-bit second-stage post-divider code and a 1-bit reference pre-divider code. A load-select input picks who owns these settings. When it is low, the settings track a set of parallel configuration pins on every clock. When it is high, a simple register port writes them and the pins are ignored. A stand-in strobe interface (address, data, write enable) replaces the serial bus engine.

Each time the active-low master reset is released, the block loads the parallel pins once, whatever the load-select level. This gives a known startup configuration, after which the serial port may take over. The reset is synchronized by a flop chain before the release is seen. A one-cycle valid pulse marks the end of this capture. A readback path always returns the settings in force, whichever source set them. A reference-select input is registered and passed on to choose between the external clock input and the crystal path.

Top module: `synth_div_cfg`

## Requirements
- R1: While `rstAsyncN` is low, the outputs are forced at once to the defaults: `cfgFb` = 0x1F4, `cfgPost` = 3'b010, `cfgPostB` = 0, `cfgPre` = 1, `refClkSel` = 1 and `cfgValid` = 0.
- R2: After `rstAsyncN` rises between two clock edges, the settings keep their defaults through the first two rising edges. At the third rising edge they take the pin values.
- R3: After the capture, while `serialSel` is 0, every rising edge copies the pins into the settings, so the outputs show the pin values from one cycle earlier.
- R4: While `serialSel` is 1 after the capture, the settings change only on a write (`wrEn` = 1). With `regAddr` = 0 the write loads `wrData[9:0]` into `cfgFb`. With `regAddr` = 1 it loads `wrData[2:0]` into `cfgPost`, `wrData[3]` into `cfgPostB` and `wrData[4]` into `cfgPre`. Pin changes have no effect.
- R5: Writes made while `serialSel` is 0 have no effect: the settings still equal the pins of the previous cycle.
- R6: The capture at reset release loads the pins even when `serialSel` is 1, and a write made in the capture cycle is dropped. Later writes act normally.
- R7: `cfgValid` is 1 for exactly one cycle. It rises at the same edge where the captured pin values first appear.
- R8: `rdData` shows the settings in force at any time and in either mode. With `regAddr` = 0 it is `cfgFb`. With `regAddr` = 1 it is `{5'b0, cfgPre, cfgPostB, cfgPost}`.
- R9: Outside reset, `refClkSel` equals `refSelIn` from the previous edge. The value 1 selects the external clock input and 0 selects the crystal path.
- R10: Pulling `rstAsyncN` low during operation restores the R1 defaults without waiting for a clock. The next release repeats the R2 capture sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstAsyncN | input | 1 | Asynchronous active-low master reset |
| serialSel | input | 1 | Load select: 0 = pins own settings, 1 = register port owns them |
| pinFb | input | 10 | Feedback count from the parallel pins |
| pinPost | input | 3 | Post-divider code from the parallel pins |
| pinPostB | input | 1 | Second-stage post-divider code from the parallel pins |
| pinPre | input | 1 | Pre-divider code from the parallel pins |
| refSelIn | input | 1 | Reference select request (1 = external clock, 0 = crystal) |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register address for writes and readback |
| wrData | input | 10 | Register write data |
| cfgFb | output | 10 | Active feedback count |
| cfgPost | output | 3 | Active post-divider code |
| cfgPostB | output | 1 | Active second-stage post-divider code |
| cfgPre | output | 1 | Active pre-divider code |
| refClkSel | output | 1 | Registered reference select |
| cfgValid | output | 1 | One-cycle pulse after the startup capture |
| rdData | output | 10 | Readback of the addressed register |

## Verification
An ownership error shows up at the ports within one cycle. If the pins leak into the serial mode, or writes leak into the pin mode, the settings differ from the expected source on the next edge. An off-by-one in the reset synchronizer or the release detection moves the capture edge and the valid pulse by a cycle. An error in the readback field packing shows on `rdData` as soon as the address selects that register. A reference model advances each cycle and is compared with every output at each falling edge, so any such error is reported in the cycle where it first appears.

// File: rtl/synth_div_cfg_pkg.sv
package synth_div_cfg_pkg;
  typedef struct packed {
    logic capture;
    logic follow;
    logic wrFb;
    logic wrCtl;
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl
  import synth_div_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstAsyncN,
  input  logic       serialSel,
  input  logic       wrEn,
  input  logic       regAddr,
  output cfgStrobe_t strb,
  output logic       cfgValid
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          relDone;
  logic          released;

  // reset synchronizer: asserts at once, releases through the flop chain
  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstAsyncN)
        if (!rstAsyncN) syncQ <= '0;
        else            syncQ <= 1'b1;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstAsyncN)
        if (!rstAsyncN) syncQ <= '0;
        else            syncQ <= {syncQ[LAST-1:0], 1'b1};
    end
  endgenerate

  assign released = syncQ[LAST];

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      relDone  <= 1'b0;
      cfgValid <= 1'b0;
    end else begin
      relDone  <= released;
      cfgValid <= strb.capture;
    end
  end

  always_comb begin
    strb.capture = released & ~relDone;
    strb.follow  = released & relDone & ~serialSel;
    strb.wrFb    = released & relDone & serialSel & wrEn & ~regAddr;
    strb.wrCtl   = released & relDone & serialSel & wrEn & regAddr;
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import synth_div_cfg_pkg::*;
#(
  parameter int              FB_W         = 10,
  parameter int              POST_W       = 3,
  parameter int              DATA_W       = 10,
  parameter logic [FB_W-1:0] FB_DEFAULT   = 10'h1F4,
  parameter logic [POST_W-1:0] POST_DEFAULT = 3'b010
) (
  input  logic              clk,
  input  logic              rstAsyncN,
  input  cfgStrobe_t        strb,
  input  logic [FB_W-1:0]   pinFb,
  input  logic [POST_W-1:0] pinPost,
  input  logic              pinPostB,
  input  logic              pinPre,
  input  logic              refSelIn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [FB_W-1:0]   cfgFb,
  output logic [POST_W-1:0] cfgPost,
  output logic              cfgPostB,
  output logic              cfgPre,
  output logic              refClkSel,
  output logic [DATA_W-1:0] rdData
);
  localparam int CTL_W = POST_W + 2;

  logic loadPins;
  assign loadPins = strb.capture | strb.follow;

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      cfgFb     <= FB_DEFAULT;
      cfgPost   <= POST_DEFAULT;
      cfgPostB  <= 1'b0;
      cfgPre    <= 1'b1;
      refClkSel <= 1'b1;
    end else begin
      refClkSel <= refSelIn;
      if (loadPins) begin
        cfgFb    <= pinFb;
        cfgPost  <= pinPost;
        cfgPostB <= pinPostB;
        cfgPre   <= pinPre;
      end else begin
        if (strb.wrFb) cfgFb <= wrData[FB_W-1:0];
        if (strb.wrCtl) begin
          cfgPost  <= wrData[POST_W-1:0];
          cfgPostB <= wrData[POST_W];
          cfgPre   <= wrData[POST_W+1];
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (regAddr) rdData[CTL_W-1:0] = {cfgPre, cfgPostB, cfgPost};
    else         rdData[FB_W-1:0]  = cfgFb;
  end
endmodule

// File: rtl/synth_div_cfg.sv
module synth_div_cfg
  import synth_div_cfg_pkg::*;
#(
  parameter int                FB_W         = 10,
  parameter int                POST_W       = 3,
  parameter int                SYNC_STAGES  = 2,
  parameter logic [FB_W-1:0]   FB_DEFAULT   = 10'h1F4,
  parameter logic [POST_W-1:0] POST_DEFAULT = 3'b010
) (
  input  logic              clk,
  input  logic              rstAsyncN,
  input  logic              serialSel,
  input  logic [FB_W-1:0]   pinFb,
  input  logic [POST_W-1:0] pinPost,
  input  logic              pinPostB,
  input  logic              pinPre,
  input  logic              refSelIn,
  input  logic              wrEn,
  input  logic              regAddr,
  input  logic [FB_W-1:0]   wrData,
  output logic [FB_W-1:0]   cfgFb,
  output logic [POST_W-1:0] cfgPost,
  output logic              cfgPostB,
  output logic              cfgPre,
  output logic              refClkSel,
  output logic              cfgValid,
  output logic [FB_W-1:0]   rdData
);
  localparam int DATA_W = FB_W;

  cfgStrobe_t strb;

  cfg_load_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstAsyncN (rstAsyncN),
    .serialSel (serialSel),
    .wrEn      (wrEn),
    .regAddr   (regAddr),
    .strb      (strb),
    .cfgValid  (cfgValid)
  );

  cfg_regfile #(
    .FB_W         (FB_W),
    .POST_W       (POST_W),
    .DATA_W       (DATA_W),
    .FB_DEFAULT   (FB_DEFAULT),
    .POST_DEFAULT (POST_DEFAULT)
  ) u_regs (
    .clk       (clk),
    .rstAsyncN (rstAsyncN),
    .strb      (strb),
    .pinFb     (pinFb),
    .pinPost   (pinPost),
    .pinPostB  (pinPostB),
    .pinPre    (pinPre),
    .refSelIn  (refSelIn),
    .regAddr   (regAddr),
    .wrData    (wrData),
    .cfgFb     (cfgFb),
    .cfgPost   (cfgPost),
    .cfgPostB  (cfgPostB),
    .cfgPre    (cfgPre),
    .refClkSel (refClkSel),
    .rdData    (rdData)
  );
endmodule

// File: rtl/synth_div_cfg_checker.sv
module synth_div_cfg_checker
  import synth_div_cfg_pkg::*;
#(
  parameter int FB_W   = 10,
  parameter int POST_W = 3
) (
  input logic              clk,
  input logic              rstAsyncN,
  input logic              serialSel,
  input logic [FB_W-1:0]   pinFb,
  input logic [POST_W-1:0] pinPost,
  input logic              wrEn,
  input logic [FB_W-1:0]   cfgFb,
  input logic [POST_W-1:0] cfgPost,
  input logic              cfgValid,
  input logic              refSelIn,
  input logic              refClkSel,
  input cfgStrobe_t        strb
);
  AST_CAPTURE_LOADS_PINS: assert property (@(posedge clk) disable iff (!rstAsyncN)
    strb.capture |=> (cfgFb == $past(pinFb)) && (cfgPost == $past(pinPost))); // R2

  AST_FOLLOW_PINS: assert property (@(posedge clk) disable iff (!rstAsyncN)
    strb.follow |=> (cfgFb == $past(pinFb)) && (cfgPost == $past(pinPost))); // R3

  AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (serialSel && !wrEn && !strb.capture) |=> $stable(cfgFb) && $stable(cfgPost)); // R4

  AST_CAPTURE_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rstAsyncN)
    strb.capture |-> !strb.wrFb && !strb.wrCtl); // R6

  AST_VALID_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rstAsyncN)
    strb.capture |=> cfgValid); // R7

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstAsyncN)
    cfgValid |=> !cfgValid); // R7

  AST_REF_DELAY: assert property (@(posedge clk) disable iff (!rstAsyncN)
    1'b1 |=> refClkSel == $past(refSelIn)); // R9
endmodule

bind synth_div_cfg synth_div_cfg_checker #(.FB_W(FB_W), .POST_W(POST_W)) u_chk (
  .clk       (clk),
  .rstAsyncN (rstAsyncN),
  .serialSel (serialSel),
  .pinFb     (pinFb),
  .pinPost   (pinPost),
  .wrEn      (wrEn),
  .cfgFb     (cfgFb),
  .cfgPost   (cfgPost),
  .cfgValid  (cfgValid),
  .refSelIn  (refSelIn),
  .refClkSel (refClkSel),
  .strb      (strb)
);

// File: tb/tb_synth_div_cfg.sv
`timescale 1ns/1ps
module tb_synth_div_cfg;
  logic       clk = 1'b0;
  logic       rstAsyncN, serialSel, pinPostB, pinPre, refSelIn, wrEn, regAddr;
  logic [9:0] pinFb, wrData;
  logic [2:0] pinPost;
  logic [9:0] cfgFb, rdData;
  logic [2:0] cfgPost;
  logic       cfgPostB, cfgPre, refClkSel, cfgValid;

  always #2.5 clk = ~clk;

  synth_div_cfg dut (
    .clk(clk), .rstAsyncN(rstAsyncN), .serialSel(serialSel),
    .pinFb(pinFb), .pinPost(pinPost), .pinPostB(pinPostB), .pinPre(pinPre),
    .refSelIn(refSelIn), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .cfgFb(cfgFb), .cfgPost(cfgPost), .cfgPostB(cfgPostB), .cfgPre(cfgPre),
    .refClkSel(refClkSel), .cfgValid(cfgValid), .rdData(rdData)
  );

  // behavioural reference model
  logic [9:0] mFb;
  logic [2:0] mPost;
  logic       mPostB, mPre, mRef, mValid;
  int         relCnt;
  logic [9:0] mRd;

  always @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      mFb <= 10'd500; mPost <= 3'b010; mPostB <= 1'b0; mPre <= 1'b1;
      mRef <= 1'b1; mValid <= 1'b0; relCnt <= 0;
    end else begin
      mRef <= refSelIn;
      if (relCnt == 2) begin
        mFb <= pinFb; mPost <= pinPost; mPostB <= pinPostB; mPre <= pinPre;
        mValid <= 1'b1;
      end else begin
        mValid <= 1'b0;
        if (relCnt >= 3) begin
          if (!serialSel) begin
            mFb <= pinFb; mPost <= pinPost; mPostB <= pinPostB; mPre <= pinPre;
          end else if (wrEn) begin
            if (!regAddr) mFb <= wrData;
            else begin
              mPost <= wrData[2:0]; mPostB <= wrData[3]; mPre <= wrData[4];
            end
          end
        end
      end
      if (relCnt < 3) relCnt <= relCnt + 1;
    end
  end

  always_comb mRd = regAddr ? {5'b0, mPre, mPostB, mPost} : mFb;

  int    cmpCnt = 0;
  int    errCnt = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always @(negedge clk) begin
    if (!done) begin
      cmpCnt++;
      if (cfgFb !== mFb || cfgPost !== mPost || cfgPostB !== mPostB ||
          cfgPre !== mPre || refClkSel !== mRef || cfgValid !== mValid ||
          rdData !== mRd) begin
        errCnt++;
        if (cfgFb !== mFb)       $display("FAIL %s cfgFb act=%h exp=%h", tag, cfgFb, mFb);
        if (cfgPost !== mPost)   $display("FAIL %s cfgPost act=%b exp=%b", tag, cfgPost, mPost);
        if (cfgPostB !== mPostB) $display("FAIL %s cfgPostB act=%b exp=%b", tag, cfgPostB, mPostB);
        if (cfgPre !== mPre)     $display("FAIL %s cfgPre act=%b exp=%b", tag, cfgPre, mPre);
        if (refClkSel !== mRef)  $display("FAIL R9 refClkSel act=%b exp=%b", refClkSel, mRef);
        if (cfgValid !== mValid) $display("FAIL R7 cfgValid act=%b exp=%b", cfgValid, mValid);
        if (rdData !== mRd)      $display("FAIL R8 rdData act=%h exp=%h", rdData, mRd);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #20000;
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog act=timeout exp=finish");
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
      $finish;
    end
  end

  initial begin
    rstAsyncN = 1'b0; serialSel = 1'b0; refSelIn = 1'b0; wrEn = 1'b0; regAddr = 1'b0;
    wrData = 10'h000; pinFb = 10'h2AB; pinPost = 3'd5; pinPostB = 1'b1; pinPre = 1'b0;
    // R1: defaults held during reset
    tag = "R1";
    step(4);
    // R2 / R7: capture on third edge after release
    tag = "R2";
    #1 rstAsyncN = 1'b1;
    step(6);
    // R3 / R8 / R9: pins followed, readback and reference select exercised
    tag = "R3";
    for (int i = 0; i < 20; i++) begin
      pinFb = 10'((i * 37 + 11) & 10'h3FF);
      pinPost = 3'(i * 3); pinPostB = i[2]; pinPre = i[1];
      regAddr = i[0]; refSelIn = i[1] ^ i[3];
      step(1);
    end
    // R5: writes in pin mode have no effect
    tag = "R5";
    wrEn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      regAddr = i[0]; wrData = 10'(i * 91 + 5);
      step(1);
    end
    wrEn = 1'b0;
    // R4: register port owns the settings
    tag = "R4";
    serialSel = 1'b1;
    for (int i = 0; i < 30; i++) begin
      pinFb = 10'(i * 53); pinPost = 3'(i); pinPostB = i[0]; pinPre = ~i[0];
      wrEn = (i % 3 != 2); regAddr = i[1]; wrData = 10'(i * 29 + 300);
      step(1);
    end
    wrEn = 1'b0;
    step(3);
    // R10: asynchronous reset mid-operation
    tag = "R10";
    #1 rstAsyncN = 1'b0;
    pinFb = 10'h155; pinPost = 3'd7; pinPostB = 1'b0; pinPre = 1'b1;
    step(3);
    // R6: capture wins over serial mode and a pending write
    tag = "R6";
    wrEn = 1'b1; regAddr = 1'b0; wrData = 10'h0AA;
    #1 rstAsyncN = 1'b1;
    step(5);
    wrData = 10'h321; step(2);
    regAddr = 1'b1; wrData = 10'h01B; step(2);
    wrEn = 1'b0;
    // R8: readback in serial mode
    tag = "R8";
    for (int i = 0; i < 6; i++) begin
      regAddr = i[0];
      step(1);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
    $finish;
  end
endmodule